// File: doc/BRIEF.md
# Processor control register file

This block holds the control state of a small 32-bit processor core: a status byte, a backup status byte, a second-level backup status byte, the condition bit, the banked interrupt and user stack pointers, two backup program counters and two plain scratch words. The core reaches it through one write port and one read port, each addressed by a 4-bit register index. A read is registered: the word for the index presented in one cycle appears on `rd_data` after the next rising edge.

The status register packs two bytes and the condition bit into one word. Bit 7 of the current status byte selects the stack mode. In user mode (0) the live general-purpose stack pointer is the user stack. In system mode (1) it is the interrupt stack. When a status write flips that bit, the block saves the live stack pointer into the bank of the mode being left and loads it from the bank of the mode being entered. It does this through a write strobe to the general register file, and the swap lands on the same clock edge as the status write. An access to the stack-pointer index of the current mode is routed to the live register. An access to the other index uses the banked copy.

Top module: `cr_file`

## Requirements
- R1: A read of index 0 (status) returns `{16'b0, bak & 8'hC1, (cur & 8'hC0) | cond}`. `bak` is the backup status byte in bits 15:8. `cur` is the current status byte. The condition bit is in bit 0.
- R2: A write of index 0 loads the backup status byte from `wr_data[15:8]`, the current status byte from `wr_data[7:0]` and the condition bit from `wr_data[0]`. `stack_mode_o` shows bit 7 of the current status byte and `cond_o` shows the condition bit.
- R3: A status write that moves bit 7 from 0 to 1 stores the live stack pointer (`gsp_in`) into the user bank. On the same edge it writes the interrupt bank value to the live stack pointer through `gsp_we`/`gsp_wdata`.
- R4: A status write that moves bit 7 from 1 to 0 stores the live stack pointer into the interrupt bank. On the same edge it writes the user bank value to the live stack pointer.
- R5: Index 2 (interrupt stack pointer) reads `gsp_in` when the stack mode is 1 and reads the banked copy otherwise. Index 3 (user stack pointer) reads `gsp_in` when the stack mode is 0 and reads the banked copy otherwise.
- R6: A write to the stack-pointer index of the current mode goes to the live stack pointer through `gsp_we`. A write to the other stack-pointer index updates its banked copy and leaves `gsp_we` low.
- R7: Indices 6 and 7 (first and second backup program counter) store 32 bits and always read with bit 0 cleared.
- R8: Index 8 (second-level backup status) stores `wr_data[7:0]` and reads back as that byte masked with 8'hC1, with all upper bits zero.
- R9: Indices 4 and 5 are plain 32-bit read/write words.
- R10: Index 1 (condition bit) writes only the condition bit from `wr_data[0]` and reads it in bit 0, with bits 31:1 zero.
- R11: Indices 9 to 15 read as zero. A write to them changes no state and does not raise `gsp_we`.
- R12: `rd_data` follows the index of the previous cycle. A read presented in the cycle of a write to the same index returns the value from before the write.
- R13: Synchronous reset clears every stored field, `rd_data`, `cond_o` and `stack_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 32 | Registered read data for the previous cycle's index |
| gsp_in | input | 32 | Current value of the live general stack pointer |
| gsp_we | output | 1 | Write strobe to the live general stack pointer |
| gsp_wdata | output | 32 | Data for the live general stack pointer |
| cond_o | output | 1 | Condition bit |
| stack_mode_o | output | 1 | Stack-mode bit (1 = interrupt stack live) |

## Verification
The assertions watch these properties on every cycle: the zero bits and masks of the status, condition, second-level backup and backup-PC reads; the zero value of unused indices; the rise of `gsp_we` on every mode-changing status write; and the absence of `gsp_we` on writes that should not touch the live stack pointer. The values themselves come only from the bench's scenarios. These are which bank receives the saved pointer, what the live pointer holds after a swap in each direction, routing between live and banked access in each mode, and the old-value result of a read that collides with a write. The bench checks them against its own model of the general stack-pointer register.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int IDX_W       = 4;
  localparam int STAT_W      = 8;
  localparam int MODE_BIT    = 7;
  localparam int STORE_BASE  = 4;
  localparam int STORE_DEPTH = 4;

  localparam logic [STAT_W-1:0] BAK_MASK = 8'hC1;
  localparam logic [STAT_W-1:0] CUR_MASK = 8'hC0;
  localparam logic [STAT_W-1:0] BB_MASK  = 8'hC1;

  typedef enum logic [IDX_W-1:0] {
    CR_STATUS = 4'd0,
    CR_COND   = 4'd1,
    CR_ISP    = 4'd2,
    CR_USP    = 4'd3,
    CR_GEN0   = 4'd4,
    CR_GEN1   = 4'd5,
    CR_BPC    = 4'd6,
    CR_BBPC   = 4'd7,
    CR_BBSTAT = 4'd8
  } cr_idx_e;
endpackage

// File: rtl/cr_status.sv
module cr_status
  import cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stat,
  input  logic              wr_cond,
  input  logic              wr_bb,
  input  logic [2*STAT_W-1:0] wd,
  output logic [STAT_W-1:0] cur_q,
  output logic [STAT_W-1:0] bak_q,
  output logic [STAT_W-1:0] bb_q,
  output logic              cond_q,
  output logic              mode,
  output logic              swap_to_sys,
  output logic              swap_to_usr
);
  assign mode        = cur_q[MODE_BIT];
  assign swap_to_sys = wr_stat & ~cur_q[MODE_BIT] &  wd[MODE_BIT];
  assign swap_to_usr = wr_stat &  cur_q[MODE_BIT] & ~wd[MODE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      bak_q  <= '0;
      bb_q   <= '0;
      cond_q <= 1'b0;
    end else begin
      if (wr_stat) begin
        cur_q  <= wd[STAT_W-1:0];
        bak_q  <= wd[2*STAT_W-1:STAT_W];
        cond_q <= wd[0];
      end else if (wr_cond) begin
        cond_q <= wd[0];
      end
      if (wr_bb) bb_q <= wd[STAT_W-1:0];
    end
  end
endmodule

// File: rtl/cr_sp_bank.sv
module cr_sp_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              swap_to_sys,
  input  logic              swap_to_usr,
  input  logic              wr_isp,
  input  logic              wr_usp,
  input  logic [DATA_W-1:0] wd,
  input  logic [DATA_W-1:0] gsp_in,
  output logic [DATA_W-1:0] isp_q,
  output logic [DATA_W-1:0] usp_q,
  output logic              gsp_we,
  output logic [DATA_W-1:0] gsp_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      isp_q <= '0;
      usp_q <= '0;
    end else if (swap_to_sys) begin
      usp_q <= gsp_in;
    end else if (swap_to_usr) begin
      isp_q <= gsp_in;
    end else if (wr_isp && !mode) begin
      isp_q <= wd;
    end else if (wr_usp && mode) begin
      usp_q <= wd;
    end
  end

  always_comb begin
    gsp_we    = 1'b0;
    gsp_wdata = '0;
    if (swap_to_sys) begin
      gsp_we    = 1'b1;
      gsp_wdata = isp_q;
    end else if (swap_to_usr) begin
      gsp_we    = 1'b1;
      gsp_wdata = usp_q;
    end else if ((wr_isp && mode) || (wr_usp && !mode)) begin
      gsp_we    = 1'b1;
      gsp_wdata = wd;
    end
  end
endmodule

// File: rtl/cr_word_store.sv
module cr_word_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [DATA_W-1:0] wd,
  input  logic [SLOT_W-1:0] rslot,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                 mem[g] <= '0;
      else if (we && wslot == SLOT_W'(g))      mem[g] <= wd;
    end
  end

  assign rword = mem[rslot];
endmodule

// File: rtl/cr_rd_compose.sv
module cr_rd_compose
  import cr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [STAT_W-1:0] cur,
  input  logic [STAT_W-1:0] bak,
  input  logic [STAT_W-1:0] bb,
  input  logic              cond,
  input  logic              mode,
  input  logic [DATA_W-1:0] isp,
  input  logic [DATA_W-1:0] usp,
  input  logic [DATA_W-1:0] gsp_in,
  input  logic [DATA_W-1:0] sword,
  output logic [DATA_W-1:0] word
);
  localparam int PAD_W = DATA_W - 2*STAT_W;

  always_comb begin
    word = '0;
    case (idx)
      CR_STATUS: word = {{PAD_W{1'b0}}, bak & BAK_MASK,
                         (cur & CUR_MASK) | {{(STAT_W-1){1'b0}}, cond}};
      CR_COND:   word = {{(DATA_W-1){1'b0}}, cond};
      CR_ISP:    word = mode  ? gsp_in : isp;
      CR_USP:    word = !mode ? gsp_in : usp;
      CR_GEN0,
      CR_GEN1:   word = sword;
      CR_BPC,
      CR_BBPC:   word = {sword[DATA_W-1:1], 1'b0};
      CR_BBSTAT: word = {{(DATA_W-STAT_W){1'b0}}, bb & BB_MASK};
      default:   word = '0;
    endcase
  end
endmodule

// File: rtl/cr_file.sv
module cr_file
  import cr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] gsp_in,
  output logic              gsp_we,
  output logic [DATA_W-1:0] gsp_wdata,
  output logic              cond_o,
  output logic              stack_mode_o
);
  localparam int SLOT_W = $clog2(STORE_DEPTH);

  logic wr_stat, wr_cond, wr_bb, wr_isp, wr_usp, wr_store, rd_store;
  logic [STAT_W-1:0] cur, bak, bb;
  logic cond, mode, to_sys, to_usr;
  logic [DATA_W-1:0] isp, usp, sword, rd_next;
  logic [IDX_W-1:0]  wofs, rofs;

  assign wr_stat  = wr_en && (wr_idx == CR_STATUS);
  assign wr_cond  = wr_en && (wr_idx == CR_COND);
  assign wr_bb    = wr_en && (wr_idx == CR_BBSTAT);
  assign wr_isp   = wr_en && (wr_idx == CR_ISP);
  assign wr_usp   = wr_en && (wr_idx == CR_USP);
  assign wofs     = wr_idx - IDX_W'(STORE_BASE);
  assign rofs     = rd_idx - IDX_W'(STORE_BASE);
  assign wr_store = wr_en && (wr_idx >= IDX_W'(STORE_BASE))
                          && (wr_idx <  IDX_W'(STORE_BASE + STORE_DEPTH));
  assign rd_store = (rd_idx >= IDX_W'(STORE_BASE))
                 && (rd_idx <  IDX_W'(STORE_BASE + STORE_DEPTH));

  cr_status u_stat (
    .clk(clk), .rst(rst),
    .wr_stat(wr_stat), .wr_cond(wr_cond), .wr_bb(wr_bb),
    .wd(wr_data[2*STAT_W-1:0]),
    .cur_q(cur), .bak_q(bak), .bb_q(bb), .cond_q(cond),
    .mode(mode), .swap_to_sys(to_sys), .swap_to_usr(to_usr)
  );

  cr_sp_bank #(.DATA_W(DATA_W)) u_sp (
    .clk(clk), .rst(rst), .mode(mode),
    .swap_to_sys(to_sys), .swap_to_usr(to_usr),
    .wr_isp(wr_isp), .wr_usp(wr_usp), .wd(wr_data), .gsp_in(gsp_in),
    .isp_q(isp), .usp_q(usp), .gsp_we(gsp_we), .gsp_wdata(gsp_wdata)
  );

  cr_word_store #(.DATA_W(DATA_W), .DEPTH(STORE_DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(wr_store),
    .wslot(wofs[SLOT_W-1:0]), .wd(wr_data),
    .rslot(rd_store ? rofs[SLOT_W-1:0] : '0), .rword(sword)
  );

  cr_rd_compose #(.DATA_W(DATA_W)) u_rd (
    .idx(rd_idx), .cur(cur), .bak(bak), .bb(bb), .cond(cond), .mode(mode),
    .isp(isp), .usp(usp), .gsp_in(gsp_in), .sword(sword), .word(rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assign cond_o       = cond;
  assign stack_mode_o = mode;
endmodule

// File: rtl/cr_file_chk.sv
module cr_file_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic [3:0]  rd_idx,
  input logic [31:0] rd_data,
  input logic        gsp_we,
  input logic        stack_mode_o
);
  a_r1_status_read_mask: assert property (@(posedge clk) disable iff (rst)
    $past(rd_idx) == 4'd0 |-> (rd_data & ~32'h0000C1C1) == 32'd0);

  a_r2_mode_follows_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 4'd0) |=> stack_mode_o == $past(wr_data[7]));

  a_r3_swap_to_sys: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 4'd0 && !stack_mode_o && wr_data[7]) |-> gsp_we);

  a_r4_swap_to_usr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 4'd0 && stack_mode_o && !wr_data[7]) |-> gsp_we);

  a_r6_no_spurious_gsp: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !gsp_we);

  a_r7_bpc_even: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_idx) == 4'd6 || $past(rd_idx) == 4'd7) |-> !rd_data[0]);

  a_r8_bbstat_mask: assert property (@(posedge clk) disable iff (rst)
    $past(rd_idx) == 4'd8 |-> (rd_data & ~32'h000000C1) == 32'd0);

  a_r10_cond_one_bit: assert property (@(posedge clk) disable iff (rst)
    $past(rd_idx) == 4'd1 |-> rd_data[31:1] == 31'd0);

  a_r11_undef_reads_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_idx) >= 4'd9 |-> rd_data == 32'd0);

  a_r11_undef_no_gsp: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= 4'd9) |-> !gsp_we);
endmodule

bind cr_file cr_file_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_idx(rd_idx), .rd_data(rd_data), .gsp_we(gsp_we),
  .stack_mode_o(stack_mode_o)
);

// File: tb/sim_cr_file.sv
module sim_cr_file;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data, gsp_wdata, gsp_m;
  logic        gsp_we, cond_o, stack_mode_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Environment model of the general-purpose stack-pointer register.
  always_ff @(posedge clk) begin
    if (rst)         gsp_m <= 32'h0000_1000;
    else if (gsp_we) gsp_m <= gsp_wdata;
  end

  cr_file u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .gsp_in(gsp_m), .gsp_we(gsp_we),
    .gsp_wdata(gsp_wdata), .cond_o(cond_o), .stack_mode_o(stack_mode_o)
  );

  // {we, widx, wdata, ridx, expected, requirement number}
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b1, 4'd4, 32'hDEAD_BEEF, 4'd4, 32'hDEAD_BEEF, 8'd9},   // R9
    {1'b1, 4'd5, 32'h1234_5678, 4'd5, 32'h1234_5678, 8'd9},   // R9
    {1'b1, 4'd6, 32'h8000_0003, 4'd6, 32'h8000_0002, 8'd7},   // R7
    {1'b1, 4'd7, 32'hFFFF_FFFF, 4'd7, 32'hFFFF_FFFE, 8'd7},   // R7
    {1'b1, 4'd8, 32'hFFFF_FFFF, 4'd8, 32'h0000_00C1, 8'd8},   // R8
    {1'b1, 4'd1, 32'hFFFF_FFFF, 4'd1, 32'h0000_0001, 8'd10},  // R10
    {1'b1, 4'd1, 32'hFFFF_FFFE, 4'd1, 32'h0000_0000, 8'd10},  // R10
    {1'b1, 4'd2, 32'h0000_2000, 4'd2, 32'h0000_2000, 8'd6},   // R6 banked isp
    {1'b1, 4'd3, 32'h0000_3000, 4'd3, 32'h0000_3000, 8'd6},   // R6 live usp
    {1'b1, 4'd0, 32'h0000_FF41, 4'd0, 32'h0000_C141, 8'd2},   // R2
    {1'b1, 4'd0, 32'h0000_0080, 4'd2, 32'h0000_2000, 8'd3},   // R3 live = old isp
    {1'b0, 4'd0, 32'h0000_0000, 4'd3, 32'h0000_3000, 8'd3},   // R3 usp banked
    {1'b1, 4'd2, 32'h0000_2400, 4'd2, 32'h0000_2400, 8'd5},   // R5 live isp
    {1'b1, 4'd0, 32'h0000_4000, 4'd3, 32'h0000_3000, 8'd4},   // R4 live = old usp
    {1'b0, 4'd0, 32'h0000_0000, 4'd2, 32'h0000_2400, 8'd4},   // R4 isp banked
    {1'b1, 4'd10, 32'hFFFF_FFFF, 4'd10, 32'h0000_0000, 8'd11}, // R11
    {1'b1, 4'd0, 32'h0000_0081, 4'd0, 32'h0000_0081, 8'd1},   // R1
    {1'b1, 4'd0, 32'h0000_C03E, 4'd0, 32'h0000_C000, 8'd1}    // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_idx = idx;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    check("R13 mode", {31'd0, stack_mode_o}, 32'd0);
    check("R13 cond", {31'd0, cond_o}, 32'd0);
    rd(4'd0, 32'd0, "R13 status");

    for (int i = 0; i < NVEC; i++) begin
      logic [80:0] v;
      v = VEC[i];
      @(negedge clk);
      wr_en = v[80]; wr_idx = v[79:76]; wr_data = v[75:44]; rd_idx = 4'd0;
      @(negedge clk);
      wr_en = 1'b0; rd_idx = v[43:40];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", v[7:0], i), rd_data, v[39:8]);
    end

    // After last vector: status C03E, mode 0, cond 0, gsp 3000, isp 2400, usp 3000
    check("R2 cond port", {31'd0, cond_o}, 32'd0);
    check("R2 mode port", {31'd0, stack_mode_o}, 32'd0);

    // R12 read colliding with write returns the old word
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd4; wr_data = 32'h0000_0055; rd_idx = 4'd4;
    @(negedge clk);
    wr_en = 1'b0;
    check("R12 old value", rd_data, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R12 new value", rd_data, 32'h0000_0055);

    // R11 undefined write: no gsp strobe, no state change
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'hFFFF_FFFF;
    #1 check("R11 gsp_we", {31'd0, gsp_we}, 32'd0);
    @(negedge clk);
    wr_en = 1'b0;
    rd(4'd4, 32'h0000_0055, "R11 scratch intact");
    rd(4'd15, 32'd0, "R11 index 15");
    check("R11 live sp", gsp_m, 32'h0000_3000);

    // R10 condition port
    wr(4'd1, 32'h0000_0001);
    check("R10 cond port", {31'd0, cond_o}, 32'd1);

    // R3 and R4 at the live stack pointer
    wr(4'd0, 32'h0000_0080);
    check("R3 mode port", {31'd0, stack_mode_o}, 32'd1);
    check("R3 live sp", gsp_m, 32'h0000_2400);
    wr(4'd0, 32'h0000_0000);
    check("R4 live sp", gsp_m, 32'h0000_3000);
    rd(4'd2, 32'h0000_2400, "R4 isp bank");

    // R13 reset in mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(4'd4, 32'd0, "R13 scratch cleared");
    rd(4'd2, 32'd0, "R13 isp cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule